// File: doc/BRIEF.md
# Palette Lookup with Posted Write Queue

This block turns an 8-bit pixel index into a 24-bit gamma-corrected color. A 256-entry palette RAM holds one color per index, and a second 256-entry gamma table maps each color channel through its own correction curve. The path from index to corrected color is a fixed two-stage pipeline: the palette read comes first, then the gamma read.

The host updates the palette through a small write queue, so a palette write never stalls the pixel side. The queue posts each write at once. Entries move into the palette RAM one per clock, only while the drain window is open and the pixel side is not reading. The host reads a free-slot count and may issue that many writes before it must read the count again. A count of zero means the queue is full. The gamma table is written directly and comes out of reset as an identity ramp.

A host word carries red in bits 31:24, green in bits 23:16 and blue in bits 15:8. Bits 7:0 are ignored. The lookup output packs red in 23:16, green in 15:8 and blue in 7:0.

Top module: `palette_fifo_lut`

## Requirements
- R1: After reset, free_count equals DEPTH (default 8) and rgb_valid is 0.
- R2: Each palette write accepted while free_count is nonzero lowers free_count by exactly one, and free_count stays within 0 to DEPTH, where 0 means full.
- R3: A palette write issued while free_count is 0 is dropped: the count stays 0 and the palette entry keeps its old value.
- R4: A palette write whose 9-bit index has bit 8 set (index above 255) is ignored. It takes no queue slot and changes no palette entry.
- R5: Queued entries drain into the palette only in cycles where drain_en is 1 and pix_valid is 0, one entry per clock, and each drain raises free_count by one.
- R6: Queued writes reach the palette in issue order, so the last of several writes to one index is the value that remains.
- R7: Palette word packing is red = bits 31:24, green = bits 23:16 and blue = bits 15:8. Bits 7:0 have no effect. The output rgb_out is {red, green, blue}.
- R8: After reset, the gamma table is an identity ramp (entry i holds i in every channel), so rgb_out equals the palette color.
- R9: rgb_out and rgb_valid appear two clock edges after pix_idx and pix_valid are sampled, and back-to-back lookups give one result per clock.
- R10: Each channel of the output is taken from the gamma entry indexed by that channel's palette value, using that channel's field of the gamma word. A gamma word has the same packing as a palette word.
- R11: After reset, every palette entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Post a palette write |
| host_wr_idx | input | 9 | Palette index; bit 8 set marks it out of range |
| host_wr_data | input | 32 | Packed palette color |
| free_count | output | 4 | Free write-queue slots, 0 = full |
| drain_en | input | 1 | Drain window open (for example, blanking) |
| gam_wr_en | input | 1 | Write a gamma table entry |
| gam_wr_idx | input | 8 | Gamma table index |
| gam_wr_data | input | 32 | Packed gamma word |
| pix_valid | input | 1 | Lookup request valid |
| pix_idx | input | 8 | Pixel index |
| rgb_out | output | 24 | Gamma-corrected color |
| rgb_valid | output | 1 | rgb_out is valid |

## Verification
The assertions check the queue count on every cycle. They cover its range, the one-step decrement on an accepted write, the dropped write while full, the ignored out-of-range index, and the freeze during lookups. They also check the one-step rise per drain cycle and the two-cycle valid delay. Only the bench scenarios can show what actually lands in the palette and what comes out of the pipeline. That covers the drain order, the masked low byte, the per-channel gamma selection, the reset contents of both tables, and that a dropped or ignored write leaves its palette entry unchanged.

// File: rtl/palette_fifo_lut.sv
module palette_fifo_lut #(
  parameter int DEPTH = 8,
  parameter int IDXW  = 8,
  localparam int ENTRIES = 1 << IDXW,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr_en,
  input  logic [IDXW:0]   host_wr_idx,
  input  logic [31:0]     host_wr_data,
  output logic [CW-1:0]   free_count,
  input  logic            drain_en,
  input  logic            gam_wr_en,
  input  logic [IDXW-1:0] gam_wr_idx,
  input  logic [31:0]     gam_wr_data,
  input  logic            pix_valid,
  input  logic [IDXW-1:0] pix_idx,
  output logic [23:0]     rgb_out,
  output logic            rgb_valid
);

  logic [IDXW-1:0] q_idx [DEPTH];
  logic [23:0]     q_dat [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   count;
  logic [23:0]     pal [ENTRIES];
  logic [23:0]     gam [ENTRIES];
  logic [23:0]     s1_rgb;
  logic            s1_v;

  wire idx_ok = ~host_wr_idx[IDXW];
  wire full   = (count == CW'(DEPTH));
  wire push   = host_wr_en & idx_ok & ~full;
  wire pop    = drain_en & ~pix_valid & (count != '0);

  assign free_count = CW'(DEPTH) - count;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        q_idx[wr_ptr] <= host_wr_idx[IDXW-1:0];
        q_dat[wr_ptr] <= host_wr_data[31:8];
        wr_ptr <= nxt(wr_ptr);
      end
      if (pop) rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) pal[i] <= '0;
    end else if (pop) begin
      pal[q_idx[rd_ptr]] <= q_dat[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) gam[i] <= {3{8'(i)}};
    end else if (gam_wr_en) begin
      gam[gam_wr_idx] <= gam_wr_data[31:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_rgb    <= '0;
      s1_v      <= 1'b0;
      rgb_out   <= '0;
      rgb_valid <= 1'b0;
    end else begin
      s1_v <= pix_valid;
      if (pix_valid) s1_rgb <= pal[pix_idx];
      rgb_valid <= s1_v;
      rgb_out <= {gam[s1_rgb[23:16]][23:16],
                  gam[s1_rgb[15:8]][15:8],
                  gam[s1_rgb[7:0]][7:0]};
    end
  end

  assert_free_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    free_count <= CW'(DEPTH));

  assert_accept_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && !host_wr_idx[IDXW] && free_count != '0 && !drain_en)
    |=> (32'(free_count) + 1 == 32'($past(free_count))));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && free_count == '0 && !(drain_en && !pix_valid))
    |=> (free_count == '0));

  assert_reject_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_wr_idx[IDXW] && !drain_en) |=> $stable(free_count));

  assert_hold_in_lookup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !host_wr_en) |=> $stable(free_count));

  assert_drain_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_en && !pix_valid && !host_wr_en && free_count != CW'(DEPTH))
    |=> (32'(free_count) == 32'($past(free_count)) + 1));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_valid == $past(pix_valid, 2));

endmodule

// File: tb/test_palette_fifo_lut.sv
module test_palette_fifo_lut;
  logic clk = 0, rst_n = 0;
  logic host_wr_en = 0, drain_en = 0, gam_wr_en = 0, pix_valid = 0;
  logic [8:0] host_wr_idx = 0;
  logic [31:0] host_wr_data = 0, gam_wr_data = 0;
  logic [7:0] gam_wr_idx = 0, pix_idx = 0;
  logic [3:0] free_count;
  logic [23:0] rgb_out;
  logic rgb_valid;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  palette_fifo_lut i_palette_fifo_lut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx),
    .host_wr_data(host_wr_data), .free_count(free_count), .drain_en(drain_en),
    .gam_wr_en(gam_wr_en), .gam_wr_idx(gam_wr_idx), .gam_wr_data(gam_wr_data),
    .pix_valid(pix_valid), .pix_idx(pix_idx), .rgb_out(rgb_out), .rgb_valid(rgb_valid));

  function automatic logic [23:0] col(input int i);
    return {8'(i * 7 + 1), 8'(i * 13 + 2), 8'(i * 29 + 3)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [8:0] idx, input logic [31:0] d);
    host_wr_en = 1; host_wr_idx = idx; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 0;
  endtask

  task automatic lookup(input logic [7:0] idx, output logic [23:0] rgb);
    pix_valid = 1; pix_idx = idx;
    @(negedge clk);
    pix_valid = 0;
    @(negedge clk);
    rgb = rgb_out;
  endtask

  task automatic drain_all();
    drain_en = 1;
    repeat (9) @(negedge clk);
    drain_en = 0;
  endtask

  task automatic t_reset();
    logic [23:0] r;
    check("R1 free after reset", 32'(free_count), 32'd8);
    check("R1 valid after reset", 32'(rgb_valid), 32'd0);
    lookup(8'd5, r);
    check("R11 palette zero", 32'(r), 32'd0);
    lookup(8'd200, r);
    check("R11 palette zero hi", 32'(r), 32'd0);
  endtask

  task automatic t_high_index();
    logic [23:0] r;
    hwrite(9'h105, 32'hDEADBE00);
    check("R4 high index no slot", 32'(free_count), 32'd8);
    drain_all();
    lookup(8'd5, r);
    check("R4 high index no write", 32'(r), 32'd0);
  endtask

  task automatic t_fill_drain();
    logic [23:0] r;
    for (int i = 0; i < 8; i++) begin
      hwrite(9'(10 + i), {col(i), 8'h5A});
      check("R2 free decrement", 32'(free_count), 32'(7 - i));
    end
    hwrite(9'd3, 32'h11223300);
    check("R3 full drop count", 32'(free_count), 32'd0);
    drain_en = 1; pix_valid = 1; pix_idx = 8'd0;
    @(negedge clk); @(negedge clk);
    check("R5 no drain during lookup", 32'(free_count), 32'd0);
    pix_valid = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R5 drain one per clock", 32'(free_count), 32'(i + 1));
    end
    drain_en = 0;
    for (int i = 0; i < 8; i++) begin
      lookup(8'(10 + i), r);
      check("R7 R8 packing identity", 32'(r), 32'(col(i)));
    end
    lookup(8'd3, r);
    check("R3 dropped write absent", 32'(r), 32'd0);
  endtask

  task automatic t_drain_gate();
    hwrite(9'd40, 32'h01020300);
    @(negedge clk); @(negedge clk);
    check("R5 no drain without window", 32'(free_count), 32'd7);
    drain_all();
    check("R5 drained", 32'(free_count), 32'd8);
  endtask

  task automatic t_order();
    logic [23:0] r;
    hwrite(9'd20, 32'hAAAAAA00);
    hwrite(9'd20, 32'h12345600);
    drain_all();
    lookup(8'd20, r);
    check("R6 last write wins", 32'(r), 32'h123456);
  endtask

  task automatic t_gamma();
    logic [23:0] r;
    hwrite(9'd30, 32'h11223300);
    drain_all();
    gam_wr_en = 1;
    gam_wr_idx = 8'h11; gam_wr_data = 32'hAA000000; @(negedge clk);
    gam_wr_idx = 8'h22; gam_wr_data = 32'h00BB0000; @(negedge clk);
    gam_wr_idx = 8'h33; gam_wr_data = 32'h0000CC00; @(negedge clk);
    gam_wr_en = 0;
    lookup(8'd30, r);
    check("R10 per-channel gamma", 32'(r), 32'hAABBCC);
  endtask

  task automatic t_stream();
    pix_valid = 1; pix_idx = 8'd10;
    @(negedge clk);
    pix_idx = 8'd11;
    @(negedge clk);
    check("R9 stream valid", 32'(rgb_valid), 32'd1);
    check("R9 stream first", 32'(rgb_out), 32'(col(0)));
    pix_idx = 8'd12;
    @(negedge clk);
    check("R9 stream second", 32'(rgb_out), 32'(col(1)));
    pix_valid = 0;
    @(negedge clk);
    check("R9 stream third", 32'(rgb_out), 32'(col(2)));
    check("R9 valid held", 32'(rgb_valid), 32'd1);
    @(negedge clk);
    check("R9 valid drops", 32'(rgb_valid), 32'd0);
  endtask

  initial begin
    #100000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_high_index();
    t_fill_drain();
    t_drain_gate();
    t_order();
    t_stream();
    t_gamma();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule